// File: doc/BRIEF.md
# Bank-Switched Memory Window Decoder

This block decodes a 16-bit processor address into chip selects for an on-board ROM, a 32 KB RAM module and a peripheral slot. The ROM holds sixteen 8 KB pages. The RAM is used as two 16 KB halves. The address space is split into four 16 KB windows. A 4-bit memory mode, held in a small register inside the block, picks how those windows are filled.

Mode zero is the power-up layout. It puts ROM at the bottom of the space, so the boot code runs from address zero. Every non-zero mode uses a single RAM-low layout. In those modes the mode value also picks which ROM page appears in the 0xC000–0xDFFF slot.

The top 8 KB always belongs to the peripheral slot, except for one word, 0xFF00. That word selects the local control port instead. Four static jumper bits are XORed into every ROM page number, so the ROM image can be moved to any page.

The decode path is purely combinational from the address to the selects. The only state is the mode register. Its load strobe and the selects are plain level signals with no valid/ready handshake, because the block neither accepts nor produces a data stream. A mode load takes effect in the cycle after the strobe.

Top module: `memwin_decoder`

## Requirements
- R1: After reset the mode register holds 0, so the boot layout of R2 applies until a mode is loaded.
- R2: In mode 0, 0x0000–0x3FFF selects ROM with page equal to address bit 13 (0 or 1). 0x4000–0x7FFF selects RAM with half = 1 in every mode. 0x8000–0xBFFF selects RAM with half = 0. 0xC000–0xDFFF selects ROM page 0.
- R3: In modes 1 to 15, 0x0000–0x3FFF selects RAM half 0, and 0x8000–0xBFFF selects ROM with page equal to address bit 13.
- R4: In modes 1 to 15, 0xC000–0xDFFF selects the ROM page whose number equals the mode value.
- R5: Any address in 0xE000–0xFFFF other than 0xFF00 asserts only the peripheral select, whatever the mode.
- R6: Address 0xFF00 asserts the port select and never the peripheral select.
- R7: The ROM page output is the page given by R2 to R4, XORed bit by bit with the 4-bit jumper input.
- R8: While the cycle strobe is low, all four selects are low.
- R9: At most one of the ROM, RAM, peripheral and port selects is high at any time.
- R10: When the load strobe is high at a clock edge, the mode becomes the load data after that edge. When the strobe is low, the mode is held.
- R11: The page output reads 0 whenever the ROM select is low. The half output reads 0 whenever the RAM select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the mode register |
| mode_load | input | 1 | Load strobe for the mode register |
| mode_din | input | 4 | New mode value |
| jumper | input | 4 | Static ROM page offset, XORed into the page |
| cyc_valid | input | 1 | Bus cycle strobe; the selects are qualified by it |
| addr | input | 16 | Processor address |
| rom_cs | output | 1 | ROM chip select |
| rom_page | output | 4 | ROM page number (0 when ROM is not selected) |
| ram_cs | output | 1 | RAM chip select |
| ram_half | output | 1 | RAM half select (0 when RAM is not selected) |
| periph_cs | output | 1 | Peripheral slot select |
| port_cs | output | 1 | Local port select at 0xFF00 |

## Verification
The bench covers every mode with several jumper settings. For each one it probes addresses across all four windows plus their exact edges.

The edges are 0x1FFF/0x2000, 0x3FFF/0x4000, 0xDFFF/0xE000 and 0xFEFF/0xFF00/0xFF01. An off-by-one in the window or slot decode shows up at these points as the wrong device selected. A decoder that treated mode 0 as just another banked mode would put RAM at address zero after reset. A decoder that missed the port override would assert two selects at 0xFF00.

Further probes cover the case where the load strobe is low but new mode data is present. They also check that no select leaks while the cycle strobe is inactive.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

  localparam int ADDR_W = 16;
  localparam int PAGE_W = 4;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_ROM    = 2'd1,
    TGT_RAM    = 2'd2,
    TGT_PERIPH = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e              tgt;
    logic [PAGE_W-1:0] page;
    logic              half;
  } route_t;

endpackage

// File: rtl/memwin_mode_reg.sv
module memwin_mode_reg #(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] din,
  output logic [MODE_W-1:0] mode
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (load) begin
      mode <= din;
    end
  end

endmodule

// File: rtl/memwin_window_map.sv
module memwin_window_map
  import memwin_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PAGE_W
) (
  input  logic [AW-1:0] addr,
  input  logic [PW-1:0] mode,
  output route_t        route
);

  localparam int WIN_HI = AW - 1;
  localparam int SUB_BIT = AW - 3;

  logic [1:0] window;
  logic       sub;
  logic       boot;

  assign window = addr[WIN_HI -: 2];
  assign sub    = addr[SUB_BIT];
  assign boot   = (mode == '0);

  always_comb begin
    route = '{tgt: TGT_NONE, page: '0, half: 1'b0};
    unique case (window)
      2'd0: begin
        if (boot) begin
          route.tgt  = TGT_ROM;
          route.page = PW'(sub);
        end else begin
          route.tgt  = TGT_RAM;
          route.half = 1'b0;
        end
      end
      2'd1: begin
        route.tgt  = TGT_RAM;
        route.half = 1'b1;
      end
      2'd2: begin
        if (boot) begin
          route.tgt  = TGT_RAM;
          route.half = 1'b0;
        end else begin
          route.tgt  = TGT_ROM;
          route.page = PW'(sub);
        end
      end
      default: begin
        if (sub) begin
          route.tgt = TGT_PERIPH;
        end else begin
          route.tgt  = TGT_ROM;
          route.page = mode;
        end
      end
    endcase
  end

endmodule

// File: rtl/memwin_select_gen.sv
module memwin_select_gen
  import memwin_pkg::*;
#(
  parameter int          AW        = ADDR_W,
  parameter int          PW        = PAGE_W,
  parameter logic [15:0] PORT_ADDR = 16'hFF00,
  parameter bit          JUMPER_EN = 1'b1
) (
  input  logic          cyc_valid,
  input  logic [AW-1:0] addr,
  input  route_t        route,
  input  logic [PW-1:0] jumper,
  output logic          rom_cs,
  output logic [PW-1:0] rom_page,
  output logic          ram_cs,
  output logic          ram_half,
  output logic          periph_cs,
  output logic          port_cs
);

  logic          port_hit;
  logic [PW-1:0] page_adj;

  assign port_hit = (addr == AW'(PORT_ADDR));

  generate
    if (JUMPER_EN) begin : g_jump
      assign page_adj = route.page ^ jumper;
    end else begin : g_nojump
      assign page_adj = route.page;
    end
  endgenerate

  always_comb begin
    rom_cs    = 1'b0;
    rom_page  = '0;
    ram_cs    = 1'b0;
    ram_half  = 1'b0;
    periph_cs = 1'b0;
    port_cs   = 1'b0;
    if (cyc_valid) begin
      if (port_hit) begin
        port_cs = 1'b1;
      end else begin
        unique case (route.tgt)
          TGT_ROM: begin
            rom_cs   = 1'b1;
            rom_page = page_adj;
          end
          TGT_RAM: begin
            ram_cs   = 1'b1;
            ram_half = route.half;
          end
          TGT_PERIPH: periph_cs = 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/memwin_decoder.sv
module memwin_decoder
  import memwin_pkg::*;
#(
  parameter logic [15:0] PORT_ADDR = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [PAGE_W-1:0] mode_din,
  input  logic [PAGE_W-1:0] jumper,
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              rom_cs,
  output logic [PAGE_W-1:0] rom_page,
  output logic              ram_cs,
  output logic              ram_half,
  output logic              periph_cs,
  output logic              port_cs
);

  logic [PAGE_W-1:0] mode_q;
  route_t            route;

  memwin_mode_reg #(.MODE_W(PAGE_W)) mode_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (mode_load),
    .din  (mode_din),
    .mode (mode_q)
  );

  memwin_window_map #(.AW(ADDR_W), .PW(PAGE_W)) map_i (
    .addr (addr),
    .mode (mode_q),
    .route(route)
  );

  memwin_select_gen #(
    .AW(ADDR_W), .PW(PAGE_W), .PORT_ADDR(PORT_ADDR), .JUMPER_EN(1'b1)
  ) sel_i (
    .cyc_valid(cyc_valid),
    .addr     (addr),
    .route    (route),
    .jumper   (jumper),
    .rom_cs   (rom_cs),
    .rom_page (rom_page),
    .ram_cs   (ram_cs),
    .ram_half (ram_half),
    .periph_cs(periph_cs),
    .port_cs  (port_cs)
  );

endmodule

// File: rtl/memwin_checker.sv
module memwin_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_load,
  input logic [3:0]  mode_din,
  input logic [3:0]  mode_q,
  input logic [3:0]  jumper,
  input logic        cyc_valid,
  input logic [15:0] addr,
  input logic        rom_cs,
  input logic [3:0]  rom_page,
  input logic        ram_cs,
  input logic        ram_half,
  input logic        periph_cs,
  input logic        port_cs
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> !(rom_cs || ram_cs || periph_cs || port_cs)); // R8

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs, periph_cs, port_cs})); // R9

  AST_PORT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && addr == 16'hFF00) |-> (port_cs && !periph_cs)); // R6

  AST_WIN1_RAM_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && addr[15:14] == 2'b01) |-> (ram_cs && ram_half)); // R2

  AST_SLOT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && addr[15:13] == 3'b110) |-> (rom_cs && rom_page == (mode_q ^ jumper))); // R4

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> (mode_q == $past(mode_din))); // R10

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_load |=> $stable(mode_q)); // R10

  AST_IDLE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rom_cs -> rom_page == 4'd0) && (!ram_cs -> !ram_half))); // R11

endmodule

bind memwin_decoder memwin_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_load(mode_load),
  .mode_din (mode_din),
  .mode_q   (mode_q),
  .jumper   (jumper),
  .cyc_valid(cyc_valid),
  .addr     (addr),
  .rom_cs   (rom_cs),
  .rom_page (rom_page),
  .ram_cs   (ram_cs),
  .ram_half (ram_half),
  .periph_cs(periph_cs),
  .port_cs  (port_cs)
);

// File: tb/memwin_decoder_tb.sv
`timescale 1ns/1ps
module memwin_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_load = 1'b0;
  logic [3:0]  mode_din = 4'd0;
  logic [3:0]  jumper = 4'd0;
  logic        cyc_valid = 1'b0;
  logic [15:0] addr = 16'd0;
  logic        rom_cs, ram_cs, ram_half, periph_cs, port_cs;
  logic [3:0]  rom_page;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  memwin_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_din(mode_din),
    .jumper(jumper), .cyc_valid(cyc_valid), .addr(addr),
    .rom_cs(rom_cs), .rom_page(rom_page), .ram_cs(ram_cs), .ram_half(ram_half),
    .periph_cs(periph_cs), .port_cs(port_cs)
  );

  // expected vector {rom_cs, rom_page[3:0], ram_cs, ram_half, periph_cs, port_cs}
  function automatic logic [8:0] expect_vec(input logic [3:0] m, input logic [3:0] j,
                                            input logic [15:0] a, input logic v);
    logic [1:0] w;
    logic       s;
    logic [3:0] pg;
    w = a[15:14];
    s = a[13];
    if (!v) return 9'd0;
    if (a == 16'hFF00) return 9'b0_0000_0001;
    if (w == 2'd3 && s) return 9'b0_0000_0010;
    if (w == 2'd3) begin pg = m; return {1'b1, pg ^ j, 4'b0000}; end
    if (w == 2'd1) return 9'b0_0000_1100;
    if (w == 2'd0) begin
      if (m == 4'd0) begin pg = {3'b000, s}; return {1'b1, pg ^ j, 4'b0000}; end
      return 9'b0_0000_1000;
    end
    if (m == 4'd0) return 9'b0_0000_1000;
    pg = {3'b000, s};
    return {1'b1, pg ^ j, 4'b0000};
  endfunction

  function automatic string tag_of(input logic [3:0] m, input logic [3:0] j,
                                   input logic [15:0] a, input logic v);
    string t;
    if (!v) return "R8";
    if (a == 16'hFF00) return "R6 R9";
    if (a[15:13] == 3'b111) return "R5 R11";
    if (a[15:13] == 3'b110) t = (m == 4'd0) ? "R2" : "R4";
    else if (a[15:14] == 2'b01) t = "R2 R11";
    else t = (m == 4'd0) ? "R2" : "R3";
    if (j != 4'd0) t = {t, " R7"};
    return t;
  endfunction

  task automatic probe(input logic [3:0] m, input logic [15:0] a, input logic v,
                       input string extra);
    logic [8:0] exp_v, act_v;
    @(negedge clk);
    addr = a;
    cyc_valid = v;
    #1;
    exp_v = expect_vec(m, jumper, a, v);
    act_v = {rom_cs, rom_page, ram_cs, ram_half, periph_cs, port_cs};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s%s mode=%0d jumper=%0d addr=%h actual=%b expected=%b",
               tag_of(m, jumper, a, v), extra, m, jumper, a, act_v, exp_v);
    end
  endtask

  task automatic load_mode(input logic [3:0] m);
    @(negedge clk);
    mode_load = 1'b1;
    mode_din = m;
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  task automatic sweep(input logic [3:0] m);
    logic [15:0] edges [17] = '{16'h0000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000,
                                16'h7FFF, 16'h8000, 16'h9FFF, 16'hA000, 16'hBFFF,
                                16'hC000, 16'hDFFF, 16'hE000, 16'hFEFF, 16'hFF00,
                                16'hFF01, 16'hFFFF};
    for (int k = 0; k < 17; k++) probe(m, edges[k], 1'b1, "");
    for (int i = 0; i < 256; i++) begin
      logic [7:0] lo;
      lo = 8'(i * 37);
      probe(m, {8'(i), lo}, 1'b1, "");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] jsel [3] = '{4'd0, 4'd5, 4'd15};
    mode_load = 1'b1;
    mode_din = 4'd9;
    repeat (3) @(posedge clk);
    @(negedge clk);
    mode_load = 1'b0;
    rst_n = 1'b1;
    // R1: boot layout right after reset (load during reset ignored)
    probe(4'd0, 16'h0000, 1'b1, " R1");
    probe(4'd0, 16'h2000, 1'b1, " R1");
    probe(4'd0, 16'h8000, 1'b1, " R1");
    probe(4'd0, 16'hC000, 1'b1, " R1");
    // R8: no selects while strobe is low
    for (int i = 0; i < 16; i++) probe(4'd0, 16'(i * 16'h1111), 1'b0, "");
    // R10: load applies, hold ignores new data
    load_mode(4'd6);
    probe(4'd6, 16'hC123, 1'b1, " R10");
    @(negedge clk);
    mode_din = 4'd11;
    repeat (3) @(negedge clk);
    probe(4'd6, 16'hC123, 1'b1, " R10");
    probe(4'd6, 16'h0000, 1'b1, " R10");
    // full sweeps over modes and jumpers
    for (int jj = 0; jj < 3; jj++) begin
      jumper = jsel[jj];
      for (int m = 0; m < 16; m++) begin
        load_mode(4'(m));
        sweep(4'(m));
      end
    end
    // R8 again under a banked mode and nonzero jumpers
    for (int i = 0; i < 16; i++) probe(4'd15, 16'(i * 16'h1011), 1'b0, "");
    // reset returns to boot layout
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    probe(4'd0, 16'h0000, 1'b1, " R1");
    probe(4'd0, 16'hD000, 1'b1, " R1");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule